// File: doc/BRIEF.md
# Target DMA Stop Controller

This block handles a host request to halt a DMA data transfer while the device acts as a bus target. When the stop command reaches the head of the command queue, the controller first checks whether a stop is allowed. That depends on the transfer mode (synchronous or asynchronous, send or receive) and on the FIFO occupancy, the transfer-count-zero flag and the synchronous-offset-at-limit flag.

If the stop is allowed, the controller does three things. It pulses a reset toward the DMA interface. It holds the DMA request line low until the data command has ended. It then finishes the bus sequence in the way the mode requires. Asynchronous transfers finish at once. A synchronous send waits for the transfer count to reach zero. A synchronous receive waits until every outstanding acknowledge has come back.

If the stop is not allowed, it is refused with an illegal-operation pulse and nothing else changes. Whenever a stop overwrites a command that was waiting in the queue, the controller flags that as well.

Top module: `tdma_stop_ctl`

## Requirements
- R1: After reset, `dma_rst`, `cmd_done`, `illegal_op`, `q_flush` and `stop_busy` are all 0, and `dma_req` follows `eng_req && xfer_active`.
- R2: A stop issued while `xfer_active` is 0 is refused. `illegal_op` is 1 in the cycle after the command, and `dma_rst` stays 0.
- R3: In a send mode (`xfer_mode[0]`=0), a stop is allowed only when `fifo_cnt` is 0.
- R4: In synchronous receive (`xfer_mode`=2'b11), a stop is allowed only when `cnt_zero` or `sofs_max` is 1.
- R5: In asynchronous receive (`xfer_mode`=2'b01), a stop is allowed only when `fifo_cnt` equals the FIFO depth (16) or `cnt_zero` is 1.
- R6: A refused stop raises `illegal_op` for exactly one cycle, starting the cycle after the command. It changes nothing else: `dma_rst`, `cmd_done` and `stop_busy` stay 0, and `dma_req` keeps following `eng_req`.
- R7: A stop issued while `queue_pend` is 1 pulses `q_flush` and `illegal_op` in the next cycle. This happens whether or not the stop is allowed, and an allowed stop still proceeds.
- R8: An allowed stop pulses `dma_rst` for exactly one cycle, starting the cycle after the command. From that cycle on, `dma_req` is 0 until `xfer_active` has been sampled 0.
- R9: In either asynchronous mode (`xfer_mode[1]`=0), an allowed stop completes at once. `cmd_done` pulses for one cycle in the same cycle as `dma_rst`, and `stop_busy` stays 0.
- R10: In synchronous send (`xfer_mode`=2'b10), `stop_busy` stays 1 until `cnt_zero` is sampled 1. `cmd_done` then pulses in the next cycle, and `stop_busy` drops in that same cycle.
- R11: In synchronous receive, `stop_busy` stays 1 until `ack_owed` is sampled as 0. `cmd_done` then pulses in the next cycle.
- R12: A stop issued while `stop_busy` is 1 is refused with `illegal_op` and does not change when the pending completion happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_cmd | input | 1 | Stop command decoded at the head of the queue (one-cycle pulse) |
| queue_pend | input | 1 | Another command is waiting behind the head |
| xfer_active | input | 1 | A DMA target send or receive data command is running |
| xfer_mode | input | 2 | bit1: 1 = synchronous; bit0: 1 = receive |
| fifo_cnt | input | FIFO_W (5) | Current FIFO byte count |
| cnt_zero | input | 1 | Transfer counter has reached zero |
| sofs_max | input | 1 | Synchronous offset is at its limit |
| ack_owed | input | ACK_W (5) | Acknowledges still outstanding on the bus |
| eng_req | input | 1 | Request from the DMA engine logic |
| dma_req | output | 1 | DMA request line after stop masking |
| dma_rst | output | 1 | One-cycle reset pulse to the DMA interface |
| cmd_done | output | 1 | One-cycle pulse when the stopped command has ended |
| illegal_op | output | 1 | One-cycle illegal-operation pulse |
| q_flush | output | 1 | One-cycle pulse: the waiting queued command was overwritten |
| stop_busy | output | 1 | A synchronous stop is waiting for its drain condition |

## Verification
A wrong legality decision shows up one cycle after the command: `illegal_op` and `dma_rst` come out swapped, and `dma_req` falls when it should not. A sequencer stuck in or out of its drain state shows as a `stop_busy` level that does not match the mode. It also shows as `cmd_done` firing in the wrong cycle relative to `cnt_zero` or `ack_owed`, and the bench sees that within one or two cycles. A request mask that does not clear shows up as a missing `dma_req` on the first cycle a new data command becomes active.

// File: rtl/tdsc_pkg.sv
package tdsc_pkg;

  // bit1 = synchronous, bit0 = receive direction
  typedef enum logic [1:0] {
    XM_ASYNC_TX = 2'b00,
    XM_ASYNC_RX = 2'b01,
    XM_SYNC_TX  = 2'b10,
    XM_SYNC_RX  = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_DRAIN = 2'b01
  } stop_state_e;

  function automatic logic mode_is_sync(xfer_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_rx(xfer_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/tdsc_gate.sv
// Decides whether a stop request may be honoured in the present transfer state.
module tdsc_gate
  import tdsc_pkg::*;
#(
  parameter int FIFO_W     = 5,
  parameter int FIFO_DEPTH = 16
) (
  input  xfer_mode_e        mode,
  input  logic              xfer_active,
  input  logic [FIFO_W-1:0] fifo_cnt,
  input  logic              cnt_zero,
  input  logic              sofs_max,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              cond_ok
);

  localparam logic [FIFO_W-1:0] FULL_CODE = FIFO_W'(FIFO_DEPTH);

  // Mode-specific condition under which halting is safe.
  function automatic logic stop_allowed(
    xfer_mode_e m,
    logic       empty,
    logic       full,
    logic       czero,
    logic       omax
  );
    logic ok;
    unique case (m)
      XM_ASYNC_TX, XM_SYNC_TX: ok = empty;
      XM_SYNC_RX:              ok = czero | omax;
      XM_ASYNC_RX:             ok = full | czero;
      default:                 ok = 1'b0;
    endcase
    return ok;
  endfunction

  assign fifo_empty = (fifo_cnt == '0);
  assign fifo_full  = (fifo_cnt == FULL_CODE);
  assign cond_ok    = xfer_active &
                      stop_allowed(mode, fifo_empty, fifo_full, cnt_zero, sofs_max);

endmodule

// File: rtl/tdsc_seq.sv
// Stop sequencer: accepts or refuses the command, then waits for the
// mode-specific drain condition before signalling completion.
module tdsc_seq
  import tdsc_pkg::*;
#(
  parameter int ACK_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_cmd,
  input  logic             queue_pend,
  input  logic             cond_ok,
  input  xfer_mode_e       mode,
  input  logic             cnt_zero,
  input  logic [ACK_W-1:0] ack_owed,
  output logic             accept,
  output logic             reject,
  output logic             overwrite,
  output logic             busy,
  output logic             dma_rst,
  output logic             cmd_done,
  output logic             illegal_op,
  output logic             q_flush
);

  stop_state_e state_q;
  xfer_mode_e  lat_mode_q;
  logic        rst_q, done_q, ill_q, flush_q;
  logic        fin_now;

  // Completion rule for a latched mode.
  function automatic logic drain_finished(
    xfer_mode_e       m,
    logic             czero,
    logic [ACK_W-1:0] owed
  );
    logic fin;
    unique case (m)
      XM_SYNC_TX: fin = czero;
      XM_SYNC_RX: fin = (owed == '0);
      default:    fin = 1'b1;
    endcase
    return fin;
  endfunction

  assign busy      = (state_q == ST_DRAIN);
  assign accept    = stop_cmd & cond_ok & ~busy;
  assign reject    = stop_cmd & ~accept;
  assign overwrite = stop_cmd & queue_pend;
  assign fin_now   = busy & drain_finished(lat_mode_q, cnt_zero, ack_owed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      lat_mode_q <= XM_ASYNC_TX;
      rst_q      <= 1'b0;
      done_q     <= 1'b0;
      ill_q      <= 1'b0;
      flush_q    <= 1'b0;
    end else begin
      rst_q   <= accept;
      ill_q   <= reject | overwrite;
      flush_q <= overwrite;
      done_q  <= 1'b0;
      if (accept) begin
        lat_mode_q <= mode;
        if (mode_is_sync(mode)) begin
          state_q <= ST_DRAIN;
        end else begin
          done_q <= 1'b1;
        end
      end else if (fin_now) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end
    end
  end

  assign dma_rst    = rst_q;
  assign cmd_done   = done_q;
  assign illegal_op = ill_q;
  assign q_flush    = flush_q;

endmodule

// File: rtl/tdsc_reqmask.sv
// Holds the DMA request low from stop acceptance until the data command ends.
module tdsc_reqmask (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic xfer_active,
  input  logic eng_req,
  output logic masked,
  output logic dma_req
);

  logic mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
    end else if (accept) begin
      mask_q <= 1'b1;
    end else if (!xfer_active) begin
      mask_q <= 1'b0;
    end
  end

  assign masked  = mask_q;
  assign dma_req = eng_req & xfer_active & ~mask_q;

endmodule

// File: rtl/tdma_stop_ctl.sv
module tdma_stop_ctl
  import tdsc_pkg::*;
#(
  parameter int FIFO_W     = 5,
  parameter int FIFO_DEPTH = 16,
  parameter int ACK_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_cmd,
  input  logic              queue_pend,
  input  logic              xfer_active,
  input  logic [1:0]        xfer_mode,
  input  logic [FIFO_W-1:0] fifo_cnt,
  input  logic              cnt_zero,
  input  logic              sofs_max,
  input  logic [ACK_W-1:0]  ack_owed,
  input  logic              eng_req,
  output logic              dma_req,
  output logic              dma_rst,
  output logic              cmd_done,
  output logic              illegal_op,
  output logic              q_flush,
  output logic              stop_busy
);

  xfer_mode_e mode_w;
  logic       cond_ok_w, fifo_empty_w, fifo_full_w;
  logic       accept_w, reject_w, overwrite_w, masked_w;

  assign mode_w = xfer_mode_e'(xfer_mode);

  tdsc_gate #(
    .FIFO_W     (FIFO_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_gate (
    .mode        (mode_w),
    .xfer_active (xfer_active),
    .fifo_cnt    (fifo_cnt),
    .cnt_zero    (cnt_zero),
    .sofs_max    (sofs_max),
    .fifo_empty  (fifo_empty_w),
    .fifo_full   (fifo_full_w),
    .cond_ok     (cond_ok_w)
  );

  tdsc_seq #(
    .ACK_W (ACK_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_cmd   (stop_cmd),
    .queue_pend (queue_pend),
    .cond_ok    (cond_ok_w),
    .mode       (mode_w),
    .cnt_zero   (cnt_zero),
    .ack_owed   (ack_owed),
    .accept     (accept_w),
    .reject     (reject_w),
    .overwrite  (overwrite_w),
    .busy       (stop_busy),
    .dma_rst    (dma_rst),
    .cmd_done   (cmd_done),
    .illegal_op (illegal_op),
    .q_flush    (q_flush)
  );

  tdsc_reqmask u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept_w),
    .xfer_active (xfer_active),
    .eng_req     (eng_req),
    .masked      (masked_w),
    .dma_req     (dma_req)
  );

endmodule

// File: rtl/tdma_stop_chk.sv
module tdma_stop_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_cmd,
  input logic queue_pend,
  input logic xfer_active,
  input logic accept,
  input logic reject,
  input logic masked,
  input logic dma_req,
  input logic dma_rst,
  input logic cmd_done,
  input logic illegal_op,
  input logic q_flush,
  input logic stop_busy
);

  // R8
  accept_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dma_rst);

  // R8
  rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rst |=> !dma_rst);

  // R8
  req_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rst |-> (!dma_req && masked));

  // R2
  idle_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd && !xfer_active) |=> (illegal_op && !dma_rst));

  // R6
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !stop_busy) |=> (!dma_rst && !cmd_done && !stop_busy));

  // R7
  overwrite_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd && queue_pend) |=> (q_flush && illegal_op));

  // R9
  done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  // R10
  drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_busy |=> (stop_busy || cmd_done));

  // R12
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_busy && stop_cmd) |=> (illegal_op && !dma_rst));

endmodule

bind tdma_stop_ctl tdma_stop_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_cmd    (stop_cmd),
  .queue_pend  (queue_pend),
  .xfer_active (xfer_active),
  .accept      (accept_w),
  .reject      (reject_w),
  .masked      (masked_w),
  .dma_req     (dma_req),
  .dma_rst     (dma_rst),
  .cmd_done    (cmd_done),
  .illegal_op  (illegal_op),
  .q_flush     (q_flush),
  .stop_busy   (stop_busy)
);

// File: tb/tb_tdma_stop_ctl.sv
`timescale 1ns/1ps
module tb_tdma_stop_ctl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_cmd = 1'b0, queue_pend = 1'b0, xfer_active = 1'b0;
  logic [1:0] xfer_mode = 2'b00;
  logic [4:0] fifo_cnt = '0;
  logic       cnt_zero = 1'b0, sofs_max = 1'b0;
  logic [4:0] ack_owed = '0;
  logic       eng_req = 1'b1;
  logic       dma_req, dma_rst, cmd_done, illegal_op, q_flush, stop_busy;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tdma_stop_ctl dut (
    .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd), .queue_pend(queue_pend),
    .xfer_active(xfer_active), .xfer_mode(xfer_mode), .fifo_cnt(fifo_cnt),
    .cnt_zero(cnt_zero), .sofs_max(sofs_max), .ack_owed(ack_owed),
    .eng_req(eng_req), .dma_req(dma_req), .dma_rst(dma_rst),
    .cmd_done(cmd_done), .illegal_op(illegal_op), .q_flush(q_flush),
    .stop_busy(stop_busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0b expected=%0b (mode=%0d fifo=%0d cz=%0b om=%0b xa=%0b qp=%0b)",
               req, act, exp, xfer_mode, fifo_cnt, cnt_zero, sofs_max, xfer_active, queue_pend);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Expected legality, restated from R2..R5
  function automatic bit may_stop(bit xa, bit [1:0] m, int f, bit cz, bit om);
    if (!xa) return 0;
    if (m[0] == 1'b0) return (f == 0);   // R3
    if (m[1] == 1'b1) return cz || om;   // R4
    return (f == 16) || cz;              // R5
  endfunction

  task automatic run_case(bit [1:0] m, int f, bit cz, bit om, bit xa, bit qp);
    bit legal, syn;
    legal = may_stop(xa, m, f, cz, om);
    syn   = m[1];
    @(negedge clk);
    xfer_active = xa; xfer_mode = m; fifo_cnt = 5'(f);
    cnt_zero = cz; sofs_max = om; queue_pend = qp; ack_owed = '0;
    eng_req = 1'b1; stop_cmd = 1'b1;
    step();
    chk(legal ? "R8 rst" : "R6 rst", dma_rst, legal);
    chk("R6/R7 illegal", illegal_op, !legal || qp);
    chk("R7 flush", q_flush, qp);
    chk("R9 done", cmd_done, legal && !syn);
    chk("R10/R11 busy", stop_busy, legal && syn);
    chk("R8 req", dma_req, xa && !legal);
    @(negedge clk);
    stop_cmd = 1'b0; queue_pend = 1'b0;
    if (syn) begin cnt_zero = 1'b0; ack_owed = 5'd2; end
    step();
    chk("R8 rst width", dma_rst, 1'b0);
    chk("R6 illegal width", illegal_op, 1'b0);
    chk("R9 done width", cmd_done, 1'b0);
    chk("R10/R11 hold", stop_busy, legal && syn);
    chk("R8 req hold", dma_req, xa && !legal);
    if (legal && syn) begin
      @(negedge clk); stop_cmd = 1'b1;
      step();
      chk("R12 illegal", illegal_op, 1'b1);
      chk("R12 busy", stop_busy, 1'b1);
      chk("R12 rst", dma_rst, 1'b0);
      @(negedge clk); stop_cmd = 1'b0;
      if (m[0]) begin
        ack_owed = 5'd1;
        step();
        chk("R11 wait", stop_busy, 1'b1);
        chk("R11 nodone", cmd_done, 1'b0);
        @(negedge clk); ack_owed = 5'd0;
      end else begin
        cnt_zero = 1'b1;
      end
      step();
      chk(m[0] ? "R11 done" : "R10 done", cmd_done, 1'b1);
      chk(m[0] ? "R11 idle" : "R10 idle", stop_busy, 1'b0);
      step();
      chk("R9 done width", cmd_done, 1'b0);
    end
    @(negedge clk);
    xfer_active = 1'b0; ack_owed = '0;
    step();
    @(negedge clk); xfer_active = 1'b1;
    #1;
    chk("R8 req release", dma_req, 1'b1);
    @(negedge clk); xfer_active = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 rst", dma_rst, 1'b0);
    chk("R1 done", cmd_done, 1'b0);
    chk("R1 illegal", illegal_op, 1'b0);
    chk("R1 flush", q_flush, 1'b0);
    chk("R1 busy", stop_busy, 1'b0);
    @(negedge clk); rst_n = 1'b1; xfer_active = 1'b1;
    #1 chk("R1 req", dma_req, 1'b1);
    @(negedge clk); xfer_active = 1'b0;
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 18; f++)
        for (int b = 0; b < 16; b++)
          run_case(2'(m), f, b[0], b[1], b[2], b[3]);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule